// File: doc/BRIEF.md
# Packed Slot Instruction Sequencer

This block fetches and decodes instructions for a small 16-bit stack machine. Each instruction word carries four short opcodes in fixed slots. The sequencer walks the slots in strict order and hands one operation at a time to an execution unit over a valid/ready handshake. It never overlaps a memory access with an issued operation.

Literal operands come in-line from the words that follow the current instruction word. A full literal uses a whole word. A byte literal uses half of one, and two byte literals in the same word share one fetched word. Control transfers take their target from the bits left in the word after their own slot, so a transfer placed early in a word reaches further. A transfer in the last slot has no bits left and takes its target from the top-of-stack value supplied by the execution side.

The program counter is a byte address. Every fetch is made at an even address. Short targets are word offsets that overwrite only the low address bits of the next sequential word, so the upper bits are kept.

Top module: `slot_sequencer`

## Requirements
- R1: After reset the block requests the word at address 0 and issues no operation until that word has arrived.
- R2: Slots issue in the order 0,1,2,3. Slot 0 is bit 15 alone, with 0 meaning NOP (op 0) and 1 meaning CALL (op 1). Slot 1 is bits 14:10, slot 2 is bits 9:5 and slot 3 is bits 4:0. Each issue reports its slot index on exSlot.
- R3: Opcode values are NOP=0, CALL=1, JMP=2, LIT=4 and LITB=5. Every other 5-bit value is issued unchanged as an ordinary operation.
- R4: A CALL in slot 0 uses bits 14:0 as a word offset, giving the target {bits14:0, 0}.
- R5: A CALL or JMP in slot 1 replaces address bits 10:1 of the current PC with word bits 9:0. In slot 2 it replaces address bits 5:1 with word bits 4:0. Bit 0 is cleared and the upper PC bits are kept. The current PC is the address of the next unread word.
- R6: A CALL or JMP in slot 3 targets tosData with bit 0 cleared, sampled at the handshake.
- R7: After a CALL or JMP is accepted, or after slot 3 is accepted, the next memory request fetches a new instruction word from the target or the current PC. Decoding then restarts at slot 0.
- R8: LIT presents the next unread word as exLit and moves the PC past that word.
- R9: The first LITB after a word fetch reads the next unread word, presents its high byte zero-extended and moves the PC on by one word. A second LITB in the same word presents the low byte of that word without a fetch. A LIT in between discards the held byte, and a new instruction word also discards it.
- R10: Every memory address is even, and memAddr stays unchanged while a request waits for memReady.
- R11: While exValid is high and exReady is low, exValid stays high and exOp and exLit stay unchanged.
- R12: On a CALL, exLink equals the current PC: the address after the instruction word and after any literal words it has consumed.
- R13: memReq and exValid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | output | 1 | Instruction memory read request |
| memAddr | output | 16 | Byte address of the requested word, always even |
| memReady | input | 1 | Read data valid this cycle; completes the request |
| memData | input | 16 | Read data |
| exValid | output | 1 | An operation is offered to execution |
| exReady | input | 1 | Execution accepts the offered operation |
| exOp | output | 5 | Opcode of the offered operation |
| exSlot | output | 2 | Slot index the operation came from |
| exLit | output | 16 | Literal operand for LIT and LITB |
| exTarget | output | 16 | Resolved target for CALL and JMP |
| exLink | output | 16 | Return address for CALL |
| tosData | input | 16 | Top-of-stack value, used as target in slot 3 |

## Verification
The assertions assume that memReady is only meaningful while memReq is high and that memData is valid in the same cycle as memReady. They also assume exReady is only acted on while exValid is high, and that tosData is valid in the cycle of the handshake it serves. The bench serves memory combinationally from a fixed program image and changes memReady, exReady and tosData only at falling edges, with random stalls on both handshakes. The program image starts with directed words that cover byte-literal pairing, an odd third byte literal, a full literal followed by a short jump, a slot-1 call and a slot-3 transfer. The rest of the image is random with weighted opcodes.

// File: rtl/seq_pkg.sv
package seq_pkg;
  parameter int WORD_W    = 16;
  parameter int SLOT_W    = 5;
  parameter int NUM_SLOTS = 4;
  localparam int SLOT_IDX_W = $clog2(NUM_SLOTS);
  localparam int HEAD_W     = WORD_W - (NUM_SLOTS - 1) * SLOT_W;
  localparam int BYTE_W     = WORD_W / 2;

  localparam logic [SLOT_W-1:0] OP_NOP  = 5'd0;
  localparam logic [SLOT_W-1:0] OP_CALL = 5'd1;
  localparam logic [SLOT_W-1:0] OP_JMP  = 5'd2;
  localparam logic [SLOT_W-1:0] OP_LIT  = 5'd4;
  localparam logic [SLOT_W-1:0] OP_LITB = 5'd5;

  typedef struct packed {
    logic wordLoad;
    logic litLoad;
    logic byteUse;
    logic slotNext;
    logic takeJump;
  } seq_strobe_t;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_DECODE = 2'd1,
    ST_LFETCH = 2'd2,
    ST_ISSUE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_strobe_t           strb,
  input  logic [WORD_W-1:0]     memData,
  input  logic [WORD_W-1:0]     tosData,
  output logic [WORD_W-1:0]     pcOut,
  output logic [SLOT_W-1:0]     curOp,
  output logic [SLOT_IDX_W-1:0] curSlot,
  output logic                  isCtl,
  output logic                  needFetch,
  output logic                  reuseByte,
  output logic                  lastSlot,
  output logic [WORD_W-1:0]     litOut,
  output logic [WORD_W-1:0]     targetOut
);
  logic [WORD_W-1:0]     pc;
  logic [WORD_W-1:0]     insnWord;
  logic [SLOT_IDX_W-1:0] slotIdx;
  logic [WORD_W-1:0]     litReg;
  logic [BYTE_W-1:0]     byteBuf;
  logic                  byteHeld;

  logic [SLOT_W-1:0] slotOps  [NUM_SLOTS];
  logic [WORD_W-1:0] slotTgts [NUM_SLOTS];

  // Per-slot opcode field and control target, laid out from the top bit down
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int REM = WORD_W - HEAD_W - s * SLOT_W;
    if (s == 0) begin : g_head
      assign slotOps[s] = {{(SLOT_W-HEAD_W){1'b0}}, insnWord[WORD_W-1 -: HEAD_W]};
    end else begin : g_body
      localparam int TOP = WORD_W - HEAD_W - 1 - (s - 1) * SLOT_W;
      assign slotOps[s] = insnWord[TOP -: SLOT_W];
    end
    if (REM > 0) begin : g_short
      localparam logic [WORD_W-1:0] TGT_MASK = WORD_W'((64'd1 << (REM + 1)) - 64'd2);
      assign slotTgts[s] = (pc & ~TGT_MASK) | ((insnWord << 1) & TGT_MASK);
    end else begin : g_stack
      assign slotTgts[s] = {tosData[WORD_W-1:1], 1'b0};
    end
  end

  assign curOp     = slotOps[slotIdx];
  assign targetOut = slotTgts[slotIdx];
  assign curSlot   = slotIdx;
  assign pcOut     = pc;
  assign litOut    = litReg;
  assign isCtl     = (curOp == OP_CALL) || (curOp == OP_JMP);
  assign needFetch = (curOp == OP_LIT) || ((curOp == OP_LITB) && !byteHeld);
  assign reuseByte = (curOp == OP_LITB) && byteHeld;
  assign lastSlot  = (slotIdx == SLOT_IDX_W'(NUM_SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc       <= '0;
      insnWord <= '0;
      slotIdx  <= '0;
      litReg   <= '0;
      byteBuf  <= '0;
      byteHeld <= 1'b0;
    end else begin
      if (strb.wordLoad) begin
        insnWord <= memData;
        pc       <= pc + WORD_W'(2);
        slotIdx  <= '0;
        byteHeld <= 1'b0;
      end
      if (strb.litLoad) begin
        pc <= pc + WORD_W'(2);
        if (curOp == OP_LITB) begin
          litReg   <= {{BYTE_W{1'b0}}, memData[WORD_W-1:BYTE_W]};
          byteBuf  <= memData[BYTE_W-1:0];
          byteHeld <= 1'b1;
        end else begin
          litReg   <= memData;
          byteHeld <= 1'b0;
        end
      end
      if (strb.byteUse) begin
        litReg   <= {{BYTE_W{1'b0}}, byteBuf};
        byteHeld <= 1'b0;
      end
      if (strb.slotNext) slotIdx <= slotIdx + SLOT_IDX_W'(1);
      if (strb.takeJump) pc <= targetOut;
    end
  end

  // A held byte must exist whenever control asks to reuse it
  assert_byte_src_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.byteUse |-> byteHeld);

  // Fetch addresses stay word aligned
  assert_even_pc_R10: assert property (@(posedge clk) disable iff (!rstN)
    pc[0] == 1'b0);
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        memReady,
  input  logic        exReady,
  input  logic        isCtl,
  input  logic        needFetch,
  input  logic        reuseByte,
  input  logic        lastSlot,
  output seq_strobe_t strb,
  output logic        memReq,
  output logic        exValid
);
  seq_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    memReq    = 1'b0;
    exValid   = 1'b0;
    unique case (state)
      ST_FETCH: begin
        memReq = 1'b1;
        if (memReady) begin
          strb.wordLoad = 1'b1;
          stateNext     = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (needFetch) begin
          stateNext = ST_LFETCH;
        end else begin
          strb.byteUse = reuseByte;
          stateNext    = ST_ISSUE;
        end
      end
      ST_LFETCH: begin
        memReq = 1'b1;
        if (memReady) begin
          strb.litLoad = 1'b1;
          stateNext    = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        exValid = 1'b1;
        if (exReady) begin
          if (isCtl) begin
            strb.takeJump = 1'b1;
            stateNext     = ST_FETCH;
          end else if (lastSlot) begin
            stateNext = ST_FETCH;
          end else begin
            strb.slotNext = 1'b1;
            stateNext     = ST_DECODE;
          end
        end
      end
      default: stateNext = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= stateNext;
  end

  assert_one_active_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && exValid));

  assert_ctl_refetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && exReady && (isCtl || lastSlot)) |=> memReq);
endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output logic        memReq,
  output logic [15:0] memAddr,
  input  logic        memReady,
  input  logic [15:0] memData,
  output logic        exValid,
  input  logic        exReady,
  output logic [4:0]  exOp,
  output logic [1:0]  exSlot,
  output logic [15:0] exLit,
  output logic [15:0] exTarget,
  output logic [15:0] exLink,
  input  logic [15:0] tosData
);
  seq_strobe_t strb;
  logic isCtl, needFetch, reuseByte, lastSlot;
  logic [WORD_W-1:0] pcVal;

  seq_control u_ctl (
    .clk(clk), .rstN(rstN), .memReady(memReady), .exReady(exReady),
    .isCtl(isCtl), .needFetch(needFetch), .reuseByte(reuseByte),
    .lastSlot(lastSlot), .strb(strb), .memReq(memReq), .exValid(exValid)
  );

  seq_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memData(memData), .tosData(tosData),
    .pcOut(pcVal), .curOp(exOp), .curSlot(exSlot), .isCtl(isCtl),
    .needFetch(needFetch), .reuseByte(reuseByte), .lastSlot(lastSlot),
    .litOut(exLit), .targetOut(exTarget)
  );

  assign memAddr = pcVal;
  assign exLink  = pcVal;

  assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr)));

  assert_issue_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (exValid && !exReady) |=> (exValid && $stable(exOp) && $stable(exLit)));
endmodule

// File: tb/slot_sequencer_tb.sv
module slot_sequencer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memReq, memReady, exValid, exReady;
  logic [15:0] memAddr, memData, exLit, exTarget, exLink, tosData;
  logic [4:0] exOp;
  logic [1:0] exSlot;
  logic memRnd;
  logic [15:0] rom [256];

  int checkCount = 0;
  int failCount  = 0;

  always #2 clk = ~clk;

  assign memReady = memReq & memRnd;
  assign memData  = rom[memAddr[8:1]];

  slot_sequencer u_dut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr),
    .memReady(memReady), .memData(memData), .exValid(exValid),
    .exReady(exReady), .exOp(exOp), .exSlot(exSlot), .exLit(exLit),
    .exTarget(exTarget), .exLink(exLink), .tosData(tosData)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] slotOp(input logic [15:0] w, input int s);
    case (s)
      0: return {4'b0, w[15]};
      1: return w[14:10];
      2: return w[9:5];
      default: return w[4:0];
    endcase
  endfunction

  function automatic logic [15:0] slotTgt(input logic [15:0] w, input int s,
                                          input logic [15:0] p, input logic [15:0] t);
    case (s)
      0: return {w[14:0], 1'b0};
      1: return {p[15:11], w[9:0], 1'b0};
      2: return {p[15:6], w[4:0], 1'b0};
      default: return {t[15:1], 1'b0};
    endcase
  endfunction

  function automatic logic [4:0] pickOp();
    int r = $urandom % 16;
    if (r < 1) return 5'd1;
    if (r < 2) return 5'd2;
    if (r < 4) return 5'd4;
    if (r < 7) return 5'd5;
    if (r < 9) return 5'd0;
    return 5'(6 + ($urandom % 26));
  endfunction

  // reference state
  logic [15:0] mPc, mWord;
  int mSlot;
  bit mHeld, mNeedWord;
  logic [7:0] mBuf;
  int opCount = 0;
  int cycles  = 0;

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++)
      rom[i] = {(($urandom % 8) == 0) ? 1'b1 : 1'b0, pickOp(), pickOp(), pickOp()};
    // directed: three byte literals, odd count
    rom[0]   = (16'd5 << 10) | (16'd5 << 5) | 16'd5;
    rom[1]   = 16'hA1B2;
    rom[2]   = 16'hC3D4;
    // full literal then slot-2 jump to word 20
    rom[3]   = (16'd4 << 10) | (16'd2 << 5) | 16'd20;
    rom[4]   = 16'h1234;
    // slot-1 call to word 100
    rom[20]  = (16'd1 << 10) | 16'h064;
    // literal then slot-3 call through stack
    rom[100] = (16'd0 << 10) | (16'd4 << 5) | 16'd1;

    mPc = 16'h0; mWord = 16'h0; mSlot = 0; mHeld = 0; mNeedWord = 1; mBuf = 8'h0;
    memRnd = 1'b0; exReady = 1'b0; tosData = 16'h0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: reset state
    check(memReq == 1'b1, "R1 memReq after reset", 16'(memReq), 16'h1);
    check(memAddr == 16'h0, "R1 first fetch address", memAddr, 16'h0);
    check(exValid == 1'b0, "R1 no issue before word", 16'(exValid), 16'h0);

    while (opCount < 3000 && cycles < 150000) begin
      @(negedge clk);
      cycles++;
      memRnd  = (($urandom % 4) != 0);
      exReady = (($urandom % 3) != 0);
      tosData = 16'($urandom);
      #1;
      check(!(memReq && exValid), "R13 exclusive activity", {memReq, exValid}, 16'h0);
      if (memReq) check(memAddr[0] == 1'b0, "R10 even address", memAddr, {memAddr[15:1], 1'b0});
      if (memReq && memReady) begin
        check(memAddr == mPc, mNeedWord ? "R7 word fetch address" : "R8 literal fetch address",
              memAddr, mPc);
        if (mNeedWord) begin
          mWord = rom[mPc[8:1]]; mPc = mPc + 16'd2; mSlot = 0; mHeld = 0; mNeedWord = 0;
        end
      end
      if (exValid && exReady) begin
        logic [4:0] eOp;
        eOp = slotOp(mWord, mSlot);
        opCount++;
        check(exOp == eOp, "R2 R3 opcode", 16'(exOp), 16'(eOp));
        check(exSlot == 2'(mSlot), "R2 slot order", 16'(exSlot), 16'(mSlot));
        case (eOp)
          5'd4: begin
            check(exLit == rom[mPc[8:1]], "R8 word literal", exLit, rom[mPc[8:1]]);
            mPc = mPc + 16'd2; mHeld = 0;
          end
          5'd5: begin
            logic [15:0] w;
            if (mHeld) begin
              check(exLit == {8'h0, mBuf}, "R9 second byte literal", exLit, {8'h0, mBuf});
              mHeld = 0;
            end else begin
              w = rom[mPc[8:1]];
              check(exLit == {8'h0, w[15:8]}, "R9 first byte literal", exLit, {8'h0, w[15:8]});
              mBuf = w[7:0]; mHeld = 1; mPc = mPc + 16'd2;
            end
          end
          5'd1, 5'd2: begin
            logic [15:0] t;
            t = slotTgt(mWord, mSlot, mPc, tosData);
            if (eOp == 5'd1) check(exLink == mPc, "R12 call link", exLink, mPc);
            if (mSlot == 0)      check(exTarget == t, "R4 slot0 target", exTarget, t);
            else if (mSlot == 3) check(exTarget == t, "R6 stack target", exTarget, t);
            else                 check(exTarget == t, "R5 short target", exTarget, t);
            mPc = t;
          end
          default: ;
        endcase
        if (eOp == 5'd1 || eOp == 5'd2 || mSlot == 3) mNeedWord = 1;
        else mSlot++;
      end
    end
    if (cycles >= 150000) begin
      failCount++;
      checkCount++;
      $display("FAIL watchdog actual %0d ops expected %0d", opCount, 3000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule